// File: doc/BRIEF.md
# Clock mode control sequencer

This block holds the 8-bit clock configuration word of a chip. It turns each write of that word into a safe, timed change of the system clock source. It drives the enable and mode code of an external oscillator, the enable of a PLL, and a 3-bit select for a downstream clock multiplexer. The select covers two internal RC sources, the oscillator input directly, and five PLL multiply taps.

Settling times are counted in ticks of a free-running reference strobe. Every write holds `busy` for a fixed transition delay. A new select is applied only when that delay has run out and the circuits the select needs have settled. A newly enabled oscillator needs a long settling period. A newly enabled PLL needs a shorter one, and it shares the oscillator period when both are enabled by the same write.

A select whose circuits are disabled is refused, and the refusal raises a sticky error flag. If a write switches off the circuit that currently supplies the clock, the select falls back to the fast RC source at once. Bit 7 of the word requests a chip reset.

Top module: `clk_mode_seq`

## Requirements
- R1: After `rst_n` is deasserted, the outputs are as follows: `src_sel` = 000, `osc_en` = 0, `pll_en` = 0, `osc_mode` = 00, `busy` = 0, `reset_req` = 0 and `mode_err` = 0.
- R2: A write is accepted on the clock edge where `wr_en` is 1. When bit 7 is 0, `busy` goes high after that edge. `busy` stays high until the later of two events: WRITE_US*TICKS_PER_US reference ticks have passed, and every circuit the requested select needs has settled. The select then changes on the next clock edge, and `busy` falls on that same edge. While `ref_tick` is held low, no settling time elapses.
- R3: A write that turns bit 5 (oscillator enable) from 0 to 1 starts a settling wait of OSC_MS*TICKS_PER_MS ticks. Selects 010 to 111 wait for that period. A PLL enabled by bit 6 in the same write settles together with the oscillator.
- R4: A write that turns bit 6 (PLL enable) from 0 to 1 while the oscillator is already enabled starts a wait of PLL_US*TICKS_PER_US ticks. PLL selects wait for that period.
- R5: Bits 2:0 of the word are the requested select. The select codes are:
  - 000: fast internal RC
  - 001: slow internal RC
  - 010: oscillator input directly
  - 011, 100, 101, 110, 111: PLL taps ×1, ×2, ×4, ×8, ×16

  The select is applied unchanged to `src_sel`.
- R6: A select of 010 written with bit 5 at 0 is invalid. A select of 011 to 111 written with bit 5 or bit 6 at 0 is also invalid. An invalid write leaves `src_sel` at its previous value and sets `mode_err`. `mode_err` stays set until the next valid write with bit 7 at 0 clears it.
- R7: A write can clear bit 5 while `src_sel` is 010 or above, or clear bit 6 while `src_sel` is 011 or above. In either case `src_sel` becomes 000 on that same clock edge.
- R8: A write with bit 7 at 1 makes `reset_req` high for exactly one cycle after the edge. It also returns every output and all internal state to the R1 values.
- R9: Bits 6, 5 and 4:3 of an accepted write appear on `pll_en`, `osc_en` and `osc_mode` after that edge. They do not change without a write. Mode codes 00, 01, 10 and 11 are external clock input, 4–16 MHz crystal, 8–32 MHz crystal and 20–60 MHz crystal.
- R10: Once both circuits have settled, a write that changes only bits 2:0 waits for the transition delay alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ref_tick | input | 1 | One-cycle strobe from the reference time base |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 8 | Configuration word: [7] reset, [6] PLL enable, [5] oscillator enable, [4:3] oscillator mode, [2:0] select |
| osc_en | output | 1 | Oscillator enable |
| osc_mode | output | 2 | Oscillator mode code |
| pll_en | output | 1 | PLL enable |
| src_sel | output | 3 | Clock source select to the multiplexer |
| busy | output | 1 | Transition in progress; the consumer stalls |
| reset_req | output | 1 | Chip reset request pulse |
| mode_err | output | 1 | Sticky invalid-select flag |

## Verification
The assertions assume that `wr_data` is meaningful only on cycles where `wr_en` is high. They also assume that `ref_tick` is a plain strobe, with no timing relation to writes. The assertions impose no limit on how often writes arrive.

The directed stimulus issues one write at a time from a negative clock edge. It then waits for `busy` to fall before the next write, except where a scenario deliberately writes during a transition. To keep wait counts exact, the stimulus holds `ref_tick` high on every cycle. The one exception is a scenario that freezes the tick, which shows that no settling time is counted without it.

// File: rtl/clk_mode_seq.sv
module clk_mode_seq #(
  parameter int TICKS_PER_US = 20,
  parameter int TICKS_PER_MS = 20000,
  parameter int WRITE_US     = 75,
  parameter int PLL_US       = 100,
  parameter int OSC_MS       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       osc_en,
  output logic [1:0] osc_mode,
  output logic       pll_en,
  output logic [2:0] src_sel,
  output logic       busy,
  output logic       reset_req,
  output logic       mode_err
);
  localparam int WR_T  = WRITE_US * TICKS_PER_US;
  localparam int PLL_T = PLL_US * TICKS_PER_US;
  localparam int OSC_T = OSC_MS * TICKS_PER_MS;
  localparam int MAX_T = (OSC_T > WR_T) ? ((OSC_T > PLL_T) ? OSC_T : PLL_T)
                                        : ((WR_T > PLL_T) ? WR_T : PLL_T);
  localparam int CW = $clog2(MAX_T + 1);

  logic [CW-1:0] wr_cnt, osc_cnt, pll_cnt;
  logic          pend;
  logic [2:0]    pend_sel;

  logic       osc_ok, pll_ok, need_ready, fire, w_osc, w_pll, sel_ok, drop;
  logic [2:0] w_sel, nxt_src;

  assign osc_ok = osc_en && (osc_cnt == '0);
  assign pll_ok = pll_en && (pll_cnt == '0) && osc_ok;

  assign need_ready = (pend_sel == 3'd2) ? osc_ok :
                      (pend_sel >= 3'd3) ? pll_ok : 1'b1;
  assign fire    = pend && (wr_cnt == '0) && need_ready;
  assign nxt_src = fire ? pend_sel : src_sel;

  assign w_pll = wr_data[6];
  assign w_osc = wr_data[5];
  assign w_sel = wr_data[2:0];
  assign sel_ok = (w_sel == 3'd2) ? w_osc :
                  (w_sel >= 3'd3) ? (w_osc && w_pll) : 1'b1;
  assign drop = (!w_osc && nxt_src >= 3'd2) || (!w_pll && nxt_src >= 3'd3);

  assign busy = (wr_cnt != '0) || pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en    <= 1'b0;
      osc_mode  <= 2'b00;
      pll_en    <= 1'b0;
      src_sel   <= 3'd0;
      reset_req <= 1'b0;
      mode_err  <= 1'b0;
      wr_cnt    <= '0;
      osc_cnt   <= '0;
      pll_cnt   <= '0;
      pend      <= 1'b0;
      pend_sel  <= 3'd0;
    end else begin
      reset_req <= 1'b0;
      if (ref_tick) begin
        if (wr_cnt  != '0) wr_cnt  <= wr_cnt  - 1'b1;
        if (osc_cnt != '0) osc_cnt <= osc_cnt - 1'b1;
        if (pll_cnt != '0) pll_cnt <= pll_cnt - 1'b1;
      end
      if (fire) begin
        src_sel <= pend_sel;
        pend    <= 1'b0;
      end
      if (wr_en) begin
        if (wr_data[7]) begin
          osc_en    <= 1'b0;
          osc_mode  <= 2'b00;
          pll_en    <= 1'b0;
          src_sel   <= 3'd0;
          reset_req <= 1'b1;
          mode_err  <= 1'b0;
          wr_cnt    <= '0;
          osc_cnt   <= '0;
          pll_cnt   <= '0;
          pend      <= 1'b0;
          pend_sel  <= 3'd0;
        end else begin
          osc_en   <= w_osc;
          pll_en   <= w_pll;
          osc_mode <= wr_data[4:3];
          wr_cnt   <= CW'(WR_T);
          if (!w_osc)
            osc_cnt <= '0;
          else if (!osc_en)
            osc_cnt <= CW'(OSC_T);
          if (!w_pll)
            pll_cnt <= '0;
          else if (!pll_en)
            pll_cnt <= (w_osc && !osc_en) ? '0 : CW'(PLL_T);
          if (sel_ok) begin
            pend     <= 1'b1;
            pend_sel <= w_sel;
            mode_err <= 1'b0;
          end else begin
            pend     <= 1'b0;
            mode_err <= 1'b1;
          end
          if (drop) src_sel <= 3'd0;
        end
      end
    end
  end
endmodule

// File: rtl/clk_mode_seq_chk.sv
module clk_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       osc_en,
  input logic [1:0] osc_mode,
  input logic       pll_en,
  input logic [2:0] src_sel,
  input logic       busy,
  input logic       reset_req,
  input logic       mode_err
);
  assert_src_has_circuit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd2) |-> osc_en);
  assert_pll_src_has_circuits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel >= 3'd3) |-> (osc_en && pll_en));
  assert_busy_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> busy);
  assert_switch_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && src_sel != 3'd0 && !$stable(src_sel)) |-> $past(busy));
  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (src_sel == 3'd0 && !osc_en && !pll_en && !busy && !mode_err));
  assert_bad_osc_sel_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && wr_data[2:0] == 3'd2 && !wr_data[5]) |=> mode_err);
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(osc_mode) && $stable(osc_en) && $stable(pll_en));
endmodule

bind clk_mode_seq clk_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .osc_en(osc_en), .osc_mode(osc_mode), .pll_en(pll_en), .src_sel(src_sel),
  .busy(busy), .reset_req(reset_req), .mode_err(mode_err)
);

// File: tb/clk_mode_seq_bench.sv
`timescale 1ns/1ps
module clk_mode_seq_bench;
  localparam int TPU = 1, TPM = 20, WUS = 75, PUS = 100, OMS = 10;
  localparam int W = WUS * TPU, P = PUS * TPU, O = OMS * TPM;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic osc_en, pll_en, busy, reset_req, mode_err;
  logic [1:0] osc_mode;
  logic [2:0] src_sel;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_mode_seq #(.TICKS_PER_US(TPU), .TICKS_PER_MS(TPM), .WRITE_US(WUS),
                 .PLL_US(PUS), .OSC_MS(OMS)) u_clk_mode_seq (
    .clk(clk), .rst_n(rst_n), .ref_tick(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .osc_en(osc_en), .osc_mode(osc_mode), .pll_en(pll_en), .src_sel(src_sel),
    .busy(busy), .reset_req(reset_req), .mode_err(mode_err));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state;
    chk("R1", "src", src_sel, 0); chk("R1", "osc_en", osc_en, 0);
    chk("R1", "pll_en", pll_en, 0); chk("R1", "osc_mode", osc_mode, 0);
    chk("R1", "busy", busy, 0); chk("R1", "reset_req", reset_req, 0);
    chk("R1", "err", mode_err, 0);
  endtask

  task automatic t_internal_switch;
    int n;
    wr(8'h01); busy_len(n);
    chk("R2", "busy cycles", n, W + 1); chk("R5", "src slow rc", src_sel, 1);
  endtask

  task automatic t_invalid_keep;
    int n;
    wr(8'h03);
    chk("R6", "src kept", src_sel, 1); chk("R6", "err set", mode_err, 1);
    busy_len(n);
    chk("R6", "src kept after delay", src_sel, 1); chk("R6", "err sticky", mode_err, 1);
    wr(8'h00);
    chk("R6", "err cleared", mode_err, 0);
    busy_len(n); chk("R5", "src fast rc", src_sel, 0);
  endtask

  task automatic t_osc_enable;
    int n;
    wr(8'h2A);
    chk("R9", "osc_en", osc_en, 1); chk("R9", "osc_mode", osc_mode, 1);
    busy_len(n);
    chk("R3", "osc settle cycles", n, O + 1); chk("R5", "src osc", src_sel, 2);
  endtask

  task automatic t_pll_after_osc;
    int n;
    wr(8'h6F); busy_len(n);
    chk("R4", "pll settle cycles", n, P + 1); chk("R5", "src x16", src_sel, 7);
  endtask

  task automatic t_free_switch;
    int n;
    wr(8'h6C); busy_len(n);
    chk("R10", "select-only cycles", n, W + 1); chk("R10", "src x2", src_sel, 4);
  endtask

  task automatic t_drop_pll;
    int n;
    wr(8'h2C);
    chk("R7", "forced fast rc", src_sel, 0); chk("R6", "err set", mode_err, 1);
    chk("R9", "pll_en off", pll_en, 0);
    busy_len(n); chk("R7", "stays fast rc", src_sel, 0);
  endtask

  task automatic t_shared_settle;
    int n;
    wr(8'h00); busy_len(n);
    wr(8'h72); busy_len(n);
    chk("R3", "joint settle cycles", n, O + 1); chk("R9", "osc_mode", osc_mode, 2);
    chk("R5", "src osc", src_sel, 2);
    wr(8'h77); busy_len(n);
    chk("R3", "pll shared period", n, W + 1); chk("R5", "src x16", src_sel, 7);
  endtask

  task automatic t_drop_osc;
    int n;
    wr(8'h41);
    chk("R7", "forced fast rc", src_sel, 0); chk("R6", "no err", mode_err, 0);
    busy_len(n); chk("R7", "then slow rc", src_sel, 1);
  endtask

  task automatic t_tick_freeze;
    int n;
    tick_en = 1'b0;
    wr(8'h00);
    repeat (300) @(negedge clk);
    chk("R2", "busy while frozen", busy, 1); chk("R2", "src held frozen", src_sel, 1);
    tick_en = 1'b1;
    busy_len(n);
    chk("R2", "cycles after thaw", n, W + 1); chk("R2", "src after thaw", src_sel, 0);
  endtask

  task automatic t_reset_bit;
    int n;
    wr(8'h6F); busy_len(n);
    wr(8'h80);
    chk("R8", "reset_req pulse", reset_req, 1);
    chk("R8", "src", src_sel, 0); chk("R8", "osc_en", osc_en, 0);
    chk("R8", "pll_en", pll_en, 0); chk("R8", "busy", busy, 0);
    @(negedge clk);
    chk("R8", "reset_req one cycle", reset_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_internal_switch();
    t_invalid_keep();
    t_osc_enable();
    t_pll_after_osc();
    t_free_switch();
    t_drop_pll();
    t_shared_settle();
    t_drop_osc();
    t_tick_freeze();
    t_reset_bit();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule